// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This unit sits beside the data side of a processor core and watches every load and store address the core issues. Software programs up to two watch addresses and a control word through a small register-write port. When a presented access matches an armed watchpoint of the right access kind, the unit raises a one-cycle abort request, so that the core can take a data abort. A two-bit hit vector goes with the request and says which watchpoints fired.

The two watch registers work either as two independent exact-address watchpoints or as a single masked range watchpoint. In range mode the second register is a don't-care mask for the first. Before any comparison, an incoming address whose top slot bits are all zero is relocated into the current process slot. The relocation takes the slot bits from a process-ID register. Nothing matches while the global debug enable bit is clear.

Top module: `wp_match_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, abort_req and abort_hit are 0. Reset clears the control word and the global enable, so no access can match until software writes them again.
- R2: A write with cfg_we high stores cfg_wdata into the register chosen by cfg_sel: 0 is watch address A, 1 is watch address B (the mask in range mode), 2 is the control word, 3 is the process ID, 4 is the global control word. Other cfg_sel values change nothing. An access presented in the same cycle as a write is compared against the old contents. The new contents apply from the next cycle.
- R3: Matching happens only while bit 31 (the top bit) of the global control word is 1.
- R4: With range mode off, watchpoint 0 hits when the relocated address equals address A, and watchpoint 1 hits when it equals address B. Both are evaluated together, so abort_hit may be 2'b11.
- R5: Control bits [1:0] set the access kind for watchpoint 0, and bits [3:2] set it for watchpoint 1. The codes are 00 off, 01 stores only, 10 loads only, 11 both. acc_store is 1 for a store and 0 for a load.
- R6: Control bit 8 selects range mode. In range mode watchpoint 0 hits when the relocated address equals address A in every bit that is clear in address B, using the kind in bits [1:0]. Watchpoint 1 never hits.
- R7: When acc_addr[31:25] are all zero, they are replaced by process-ID bits [31:25] before the comparison. Otherwise the address is used unchanged.
- R8: abort_req is high in the cycle after the matching access is presented, for that one cycle only. abort_hit bit i is set when watchpoint i hit. abort_hit is 0 whenever abort_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | 32 | Virtual address of the access |
| acc_store | input | 1 | 1 store, 0 load |
| abort_req | output | 1 | Data abort request pulse |
| abort_hit | output | 2 | Which watchpoints hit |

## Verification
An access is compared combinationally and its result is captured on the next rising edge, so abort_req and abort_hit are due exactly one edge after the access. The bench drives each access just after an edge and reads the outputs just after the following edge, then checks on the edge after that that the pulse has dropped. Register writes land on the edge that ends the write cycle. A collision case therefore presents a write and an access in the same cycle and expects the old contents, then repeats the access and expects the new ones.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [1:0] {
      KIND_OFF   = 2'b00,
      KIND_STORE = 2'b01,
      KIND_LOAD  = 2'b10,
      KIND_ANY   = 2'b11
   } acc_kind_e;

   localparam int SEL_W        = 3;
   localparam int SEL_ADDR_A   = 0;
   localparam int SEL_ADDR_B   = 1;
   localparam int SEL_CTRL     = 2;
   localparam int SEL_PROC_ID  = 3;
   localparam int SEL_GLOBAL   = 4;

   localparam int CTRL_K0_LSB  = 0;
   localparam int CTRL_K1_LSB  = 2;
   localparam int CTRL_RANGE   = 8;

   function automatic logic kind_accepts(acc_kind_e k, logic is_store);
      case (k)
         KIND_STORE: kind_accepts = is_store;
         KIND_LOAD:  kind_accepts = !is_store;
         KIND_ANY:   kind_accepts = 1'b1;
         default:    kind_accepts = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/wp_regs.sv
module wp_regs
   import wp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] addr_a,
   output logic [ADDR_W-1:0] addr_b,
   output acc_kind_e         kind0,
   output acc_kind_e         kind1,
   output logic              range_mode,
   output logic [SLOT_W-1:0] slot_bits,
   output logic              gen_en
);

   localparam int GEN_BIT = ADDR_W - 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_a     <= '0;
         addr_b     <= '0;
         kind0      <= KIND_OFF;
         kind1      <= KIND_OFF;
         range_mode <= 1'b0;
         slot_bits  <= '0;
         gen_en     <= 1'b0;
      end else if (we) begin
         case (int'(sel))
            SEL_ADDR_A:  addr_a <= wdata;
            SEL_ADDR_B:  addr_b <= wdata;
            SEL_CTRL: begin
               kind0      <= acc_kind_e'(wdata[CTRL_K0_LSB +: 2]);
               kind1      <= acc_kind_e'(wdata[CTRL_K1_LSB +: 2]);
               range_mode <= wdata[CTRL_RANGE];
            end
            SEL_PROC_ID: slot_bits <= wdata[ADDR_W-1 -: SLOT_W];
            SEL_GLOBAL:  gen_en    <= wdata[GEN_BIT];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/wp_remap.sv
module wp_remap #(
   parameter int ADDR_W = 32,
   parameter int SLOT_W = 7
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [SLOT_W-1:0] slot_bits,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int LOW_W = ADDR_W - SLOT_W;

   logic [SLOT_W-1:0] top_bits;
   logic [LOW_W-1:0]  low_bits;

   always_comb begin
      top_bits = addr_in[ADDR_W-1 -: SLOT_W];
      low_bits = addr_in[LOW_W-1:0];
      if (top_bits == '0)
         addr_out = {slot_bits, low_bits};
      else
         addr_out = addr_in;
   end

endmodule

// File: rtl/wp_cmp.sv
module wp_cmp
   import wp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_store,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] care_mask,
   input  acc_kind_e         kind,
   input  logic              allow,
   output logic              hit
);

   logic [ADDR_W-1:0] diff;

   always_comb begin
      diff = (addr ^ ref_addr) & care_mask;
      hit  = allow && kind_accepts(kind, is_store) && (diff == '0);
   end

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
   import wp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLOT_W = 7,
   parameter int NUM_WP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              acc_valid,
   input  logic [31:0]       acc_addr,
   input  logic              acc_store,
   output logic              abort_req,
   output logic [1:0]        abort_hit
);

   generate
      if (ADDR_W != 32)
         $error("wp_match_unit: ADDR_W must match the 32-bit port width");
      if (SLOT_W < 1 || SLOT_W >= ADDR_W)
         $error("wp_match_unit: SLOT_W must lie in 1..ADDR_W-1");
      if (NUM_WP != 2)
         $error("wp_match_unit: exactly two watchpoints are supported");
   endgenerate

   logic [ADDR_W-1:0] addr_a, addr_b, rel_addr;
   acc_kind_e         kind0, kind1;
   logic              range_mode, gen_en;
   logic [SLOT_W-1:0] slot_bits;
   logic [NUM_WP-1:0] hit_vec;
   logic              hit_any;

   wp_regs #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .sel        (cfg_sel),
      .wdata      (cfg_wdata),
      .addr_a     (addr_a),
      .addr_b     (addr_b),
      .kind0      (kind0),
      .kind1      (kind1),
      .range_mode (range_mode),
      .slot_bits  (slot_bits),
      .gen_en     (gen_en)
   );

   wp_remap #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_remap (
      .addr_in   (acc_addr),
      .slot_bits (slot_bits),
      .addr_out  (rel_addr)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_WP; gi++) begin : g_wp
         if (gi == 0) begin : g_base
            logic [ADDR_W-1:0] care;
            assign care = range_mode ? ~addr_b : '1;
            wp_cmp #(.ADDR_W(ADDR_W)) u_cmp (
               .addr      (rel_addr),
               .is_store  (acc_store),
               .ref_addr  (addr_a),
               .care_mask (care),
               .kind      (kind0),
               .allow     (acc_valid && gen_en),
               .hit       (hit_vec[gi])
            );
         end else begin : g_pair
            wp_cmp #(.ADDR_W(ADDR_W)) u_cmp (
               .addr      (rel_addr),
               .is_store  (acc_store),
               .ref_addr  (addr_b),
               .care_mask ('1),
               .kind      (kind1),
               .allow     (acc_valid && gen_en && !range_mode),
               .hit       (hit_vec[gi])
            );
         end
      end
   endgenerate

   assign hit_any = |hit_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abort_req <= 1'b0;
         abort_hit <= '0;
      end else begin
         abort_req <= hit_any;
         abort_hit <= hit_vec;
      end
   end

endmodule

// File: rtl/wp_match_chk.sv
module wp_match_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_valid,
   input logic       acc_store,
   input logic       gen_en,
   input logic       range_mode,
   input logic [1:0] kind0,
   input logic [1:0] kind1,
   input logic       abort_req,
   input logic [1:0] abort_hit
);

   // R8
   pulse_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> abort_hit != 2'b00);

   // R8
   idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_req |-> abort_hit == 2'b00);

   // R3
   global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> $past(gen_en && acc_valid));

   // R6
   range_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && $past(range_mode)) |-> !abort_hit[1]);

   // R5
   store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_hit[0] && $past(kind0) == 2'b01) |-> $past(acc_store));

   // R5
   off_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_hit[1] |-> $past(kind1) != 2'b00);

endmodule

bind wp_match_unit wp_match_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_store  (acc_store),
   .gen_en     (gen_en),
   .range_mode (range_mode),
   .kind0      (kind0),
   .kind1      (kind1),
   .abort_req  (abort_req),
   .abort_hit  (abort_hit)
);

// File: tb/wp_match_unit_tb.sv
module wp_match_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_store = 1'b0;
   logic        abort_req;
   logic [1:0]  abort_hit;

   int n_run = 0;
   int n_fail = 0;

   logic [31:0] m_a = '0, m_b = '0, m_pid = '0;
   logic [1:0]  m_k0 = '0, m_k1 = '0;
   logic        m_range = 1'b0, m_gen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_match_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_store(acc_store), .abort_req(abort_req), .abort_hit(abort_hit)
   );

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   function automatic logic kind_ok(logic [1:0] k, logic st);
      return (k == 2'b11) || (k == 2'b01 && st) || (k == 2'b10 && !st);
   endfunction

   function automatic logic [1:0] model(logic [31:0] addr, logic st);
      logic [31:0] a;
      logic h0, h1;
      if (!m_gen) return 2'b00;
      a = addr;
      if (a[31:25] == 7'd0) a[31:25] = m_pid[31:25];
      if (m_range) begin
         h0 = kind_ok(m_k0, st) && (((a ^ m_a) & ~m_b) == 32'd0);
         h1 = 1'b0;
      end else begin
         h0 = kind_ok(m_k0, st) && (a == m_a);
         h1 = kind_ok(m_k1, st) && (a == m_b);
      end
      return {h1, h0};
   endfunction

   task automatic check(input string req, input logic [1:0] exp);
      n_run++;
      if (abort_req !== (exp != 2'b00) || abort_hit !== exp) begin
         n_fail++;
         $display("FAIL %s: req=%0b hit=%b expected req=%0b hit=%b",
                  req, abort_req, abort_hit, exp != 2'b00, exp);
      end
   endtask

   task automatic model_write(input logic [2:0] sel, input logic [31:0] d);
      case (sel)
         3'd0: m_a = d;
         3'd1: m_b = d;
         3'd2: begin m_k0 = d[1:0]; m_k1 = d[3:2]; m_range = d[8]; end
         3'd3: m_pid = d;
         3'd4: m_gen = d[31];
         default: ;
      endcase
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      model_write(sel, d);
   endtask

   // access, check result one edge later, then check the pulse has dropped
   task automatic probe(input logic [31:0] addr, input logic st, input string req);
      logic [1:0] exp;
      exp = model(addr, st);
      acc_valid = 1'b1; acc_addr = addr; acc_store = st;
      @(posedge clk); #1;
      acc_valid = 1'b0;
      check(req, exp);
      @(posedge clk); #1;
      check("R8 single-cycle", 2'b00);
   endtask

   initial begin
      logic [31:0] seed;
      logic [1:0]  old_exp;
      seed = 32'h1234_5678;

      repeat (3) @(posedge clk); #1;
      check("R1 during reset", 2'b00);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 after reset", 2'b00);
      // R1: registers hold zero, enables cleared: address 0 must not match
      probe(32'h0000_0000, 1'b1, "R1 enables cleared");
      probe(32'h0000_0000, 1'b0, "R1 enables cleared");

      // R3: watch armed but global enable off
      wr(3'd0, 32'h1000_0040);
      wr(3'd1, 32'h1000_0080);
      wr(3'd2, 32'h0000_000F);
      probe(32'h1000_0040, 1'b1, "R3 global off");
      wr(3'd4, 32'h7FFF_FFFF);
      probe(32'h1000_0040, 1'b1, "R3 bit31 clear");
      wr(3'd4, 32'h8000_0000);
      probe(32'h1000_0040, 1'b1, "R3 global on");

      // R2: unused selects change nothing
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'h0000_0000);
      wr(3'd7, 32'h0000_0000);
      probe(32'h1000_0040, 1'b0, "R2 unused select");
      probe(32'h1000_0080, 1'b1, "R2 unused select");

      // R4/R5 sweep all kind pairs, both directions, three addresses
      for (int k0 = 0; k0 < 4; k0++) begin
         for (int k1 = 0; k1 < 4; k1++) begin
            wr(3'd2, {28'd0, k1[1:0], k0[1:0]});
            for (int st = 0; st < 2; st++) begin
               probe(32'h1000_0040, st[0], "R5 kind wp0");
               probe(32'h1000_0080, st[0], "R5 kind wp1");
               probe(32'h1000_00C0, st[0], "R4 miss");
            end
         end
      end

      // R4: both watchpoints on one address hit together
      wr(3'd1, 32'h1000_0040);
      wr(3'd2, 32'h0000_000F);
      probe(32'h1000_0040, 1'b0, "R4 dual hit");

      // R2: write and access in the same cycle see the old value
      old_exp = model(32'h3000_0100, 1'b1);
      cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h3000_0100;
      acc_valid = 1'b1; acc_addr = 32'h3000_0100; acc_store = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0; acc_valid = 1'b0;
      model_write(3'd0, 32'h3000_0100);
      check("R2 old value in write cycle", old_exp);
      probe(32'h3000_0100, 1'b1, "R2 new value next cycle");

      // R6: range mode sweep, wp1 kind armed but must stay silent
      wr(3'd0, 32'h2000_1200);
      wr(3'd1, 32'h0000_00F3);
      wr(3'd2, 32'h0000_010F);
      for (int off = 0; off < 512; off++)
         probe(32'h2000_1100 + off, off[0], "R6 range");
      probe(32'h0000_00F3, 1'b1, "R6 wp1 silent");
      wr(3'd2, 32'h0000_0109);
      for (int off = 0; off < 64; off++)
         probe(32'h2000_11C0 + off, off[1], "R6 range store-only");

      // R7: slot relocation
      wr(3'd3, 32'h0A00_0000);
      wr(3'd0, 32'h0A00_3000);
      wr(3'd1, 32'h0000_5000);
      wr(3'd2, 32'h0000_000F);
      probe(32'h0000_3000, 1'b0, "R7 relocated hit");
      probe(32'h0A00_3000, 1'b0, "R7 direct hit");
      probe(32'h1400_3000, 1'b0, "R7 other slot");
      probe(32'h0000_5000, 1'b1, "R7 relocated away");
      probe(32'h0200_3000, 1'b1, "R7 non-zero top");

      // R4/R6/R7 pseudo-random mix near the watch values
      for (int i = 0; i < 400; i++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         if (i % 100 == 0) begin
            wr(3'd2, {23'd0, seed[20], 4'd0, seed[3:0]});
            wr(3'd3, {seed[31:25], 25'd0});
         end
         case (seed[9:8])
            2'd0: probe(m_a ^ {24'd0, seed[7:0] & 8'h0F}, seed[10], "R4 random");
            2'd1: probe(m_b, seed[10], "R4 random");
            2'd2: probe({7'd0, m_a[24:0]}, seed[10], "R7 random");
            default: probe(seed, seed[10], "R4 random");
         endcase
      end

      // R1: reset again clears enables
      rst_n = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b1;
      m_k0 = 2'b00; m_k1 = 2'b00; m_range = 1'b0; m_gen = 1'b0;
      m_a = '0; m_b = '0; m_pid = '0;
      probe(32'h0A00_3000, 1'b0, "R1 re-reset");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule